// File: doc/BRIEF.md
# Per-Core Local Interrupt Aggregator

This block collects the interrupt sources that belong to each core of a small cluster and turns them into one interrupt request line per core. Each core has four timer lines, a mailbox line and a performance-monitor line. A single fast interrupt from a companion processor is also collected, and it goes to core 0 only. The timer and mailbox lines pass through per-core enable words. The performance-monitor lines pass through a core routing mask that software changes only through a set register and a clear register.

Software reads a per-core pending word. The bit order of that word is the service priority: the servicing code takes the lowest set bit first. The pending words and the request lines are purely combinational and level-sensitive. A source that drops removes its bit at once, and nothing is latched here. The mailbox storage and the timer counters sit outside this block and reach it only as input lines.

The register bus uses word addresses with an 8-bit byte address. A write takes effect on the next rising clock edge. A read is combinational from `bus_addr`.

Top module: `lirq_agg`

## Requirements
- R1: After reset, every timer enable, mailbox enable and routing bit is zero, every pending word reads zero and every `core_irq` bit is low.
- R2: The timer enable word of core c is at byte address 0x40 + 4*c. A write stores wdata[3:0], with bit 0 for secure physical, bit 1 for non-secure physical, bit 2 for hypervisor and bit 3 for virtual. A read returns those four bits, and bits 31:4 read zero.
- R3: The mailbox enable word of core c is at 0x50 + 4*c. Only bit 0 is stored, and the other bits read zero.
- R4: A write to 0x08 sets routing bit n for every set wdata bit n (n < 4), and leaves the other routing bits unchanged. A write to 0x0C clears those bits in the same way. Reads of 0x08 and 0x0C both return the routing mask in bits 3:0.
- R5: The pending word of core c is at 0x60 + 4*c and has the following bits:
  - bits 3:0 are timer input & timer enable;
  - bit 4 is mailbox input & mailbox enable;
  - bit 8 is `fast_irq_in` for core 0 and always 0 for the other cores, with no mask;
  - bit 9 is `pmu_irq_in[c]` & routing bit c;
  - all other bits are zero.
- R6: `core_irq[c]` is the OR of the pending word of core c. It follows the inputs combinationally, with no latching.
- R7: Writes to the pending addresses and to unmapped addresses change no state. Reads of unmapped addresses return zero.
- R8: A register write does not change `core_irq` before the rising edge that captures it, and does change it right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tmr_irq_in | input | 16 | Timer lines, 4 per core, core c at [4c+3:4c] |
| mbox_irq_in | input | 4 | Mailbox line per core |
| pmu_irq_in | input | 4 | Performance-monitor line per core |
| fast_irq_in | input | 1 | Shared fast interrupt line |
| core_irq | output | 4 | Interrupt request per core |

## Verification
The bench builds the block with its default of four cores, an 8-bit address and a 32-bit data word. At that size every combination is within reach:
- each core's 16 timer-enable values are tried against all 16 timer-input patterns;
- all 16 routing masks are built through the set and clear registers;
- every mailbox enable/input pair is tried on every core.

The expected pending words are formed arithmetically from the stated bit positions. The bench also checks the edge at which a write becomes visible.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NTMR   = 4;
  localparam int PW     = 10;
  localparam int P_TMR  = 0;
  localparam int P_MBOX = 4;
  localparam int P_FAST = 8;
  localparam int P_PMU  = 9;

  localparam int OFS_PMU_SET = 'h08;
  localparam int OFS_PMU_CLR = 'h0C;
  localparam int OFS_TMR     = 'h40;
  localparam int OFS_MBOX    = 'h50;
  localparam int OFS_PEND    = 'h60;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int NC = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [NC*NTMR-1:0]   tmr_en,
  output logic [NC-1:0]        mbox_en,
  output logic [NC-1:0]        pmu_route
);
  localparam logic [AW-1:0] A_SET = AW'(OFS_PMU_SET);
  localparam logic [AW-1:0] A_CLR = AW'(OFS_PMU_CLR);

  wire lirq_unused_wd = ^wdata[DW-1:NTMR];

  // routing mask: write-one-to-set / write-one-to-clear
  logic          set_hit, clr_hit, route_ce;
  logic [NC-1:0] route_d;

  assign set_hit  = wr && (addr == A_SET);
  assign clr_hit  = wr && (addr == A_CLR);
  assign route_ce = set_hit || clr_hit;

  always_comb begin
    route_d = pmu_route;
    if (set_hit) route_d = pmu_route | wdata[NC-1:0];
    if (clr_hit) route_d = pmu_route & ~wdata[NC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pmu_route <= '0;
    else if (route_ce) pmu_route <= route_d;
  end

  // per-core enable words
  for (genvar c = 0; c < NC; c++) begin : g_core
    localparam logic [AW-1:0] A_TMR = AW'(OFS_TMR + 4*c);
    localparam logic [AW-1:0] A_MBX = AW'(OFS_MBOX + 4*c);

    logic            tmr_ce, mbx_ce;
    logic [NTMR-1:0] tmr_d, tmr_q;
    logic            mbx_d, mbx_q;

    assign tmr_ce = wr && (addr == A_TMR);
    assign mbx_ce = wr && (addr == A_MBX);
    assign tmr_d  = wdata[NTMR-1:0];
    assign mbx_d  = wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tmr_q <= '0;
      else if (tmr_ce) tmr_q <= tmr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mbx_q <= 1'b0;
      else if (mbx_ce) mbx_q <= mbx_d;
    end

    assign tmr_en[c*NTMR +: NTMR] = tmr_q;
    assign mbox_en[c]             = mbx_q;
  end
endmodule

// File: rtl/lirq_pend.sv
module lirq_pend
  import lirq_pkg::*;
#(
  parameter int CORE = 0
) (
  input  logic [NTMR-1:0] tmr_in,
  input  logic [NTMR-1:0] tmr_en,
  input  logic            mbox_in,
  input  logic            mbox_en,
  input  logic            fast_in,
  input  logic            pmu_in,
  input  logic            pmu_rt,
  output logic [PW-1:0]   pend,
  output logic            irq
);
  logic fast_sel;

  if (CORE == 0) begin : g_fast
    assign fast_sel = fast_in;
  end else begin : g_nofast
    assign fast_sel = 1'b0;
    wire lirq_unused_fast = fast_in;
  end

  always_comb begin
    pend                  = '0;
    pend[P_TMR +: NTMR]   = tmr_in & tmr_en;
    pend[P_MBOX]          = mbox_in & mbox_en;
    pend[P_FAST]          = fast_sel;
    pend[P_PMU]           = pmu_in & pmu_rt;
  end

  assign irq = |pend;
endmodule

// File: rtl/lirq_agg.sv
module lirq_agg
  import lirq_pkg::*;
#(
  parameter int NC = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NC*NTMR-1:0]  tmr_irq_in,
  input  logic [NC-1:0]       mbox_irq_in,
  input  logic [NC-1:0]       pmu_irq_in,
  input  logic                fast_irq_in,
  output logic [NC-1:0]       core_irq
);
  logic [NC*NTMR-1:0]   tmr_en_w;
  logic [NC-1:0]        mbox_en_w;
  logic [NC-1:0]        pmu_route_w;
  logic [NC-1:0][PW-1:0] pend_w;

  lirq_regs #(.NC(NC), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .tmr_en    (tmr_en_w),
    .mbox_en   (mbox_en_w),
    .pmu_route (pmu_route_w)
  );

  for (genvar c = 0; c < NC; c++) begin : g_pend
    lirq_pend #(.CORE(c)) u_pend (
      .tmr_in  (tmr_irq_in[c*NTMR +: NTMR]),
      .tmr_en  (tmr_en_w[c*NTMR +: NTMR]),
      .mbox_in (mbox_irq_in[c]),
      .mbox_en (mbox_en_w[c]),
      .fast_in (fast_irq_in),
      .pmu_in  (pmu_irq_in[c]),
      .pmu_rt  (pmu_route_w[c]),
      .pend    (pend_w[c]),
      .irq     (core_irq[c])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_PMU_SET) || bus_addr == AW'(OFS_PMU_CLR))
      bus_rdata[NC-1:0] = pmu_route_w;
    for (int c = 0; c < NC; c++) begin
      if (bus_addr == AW'(OFS_TMR + 4*c))
        bus_rdata[NTMR-1:0] = tmr_en_w[c*NTMR +: NTMR];
      if (bus_addr == AW'(OFS_MBOX + 4*c))
        bus_rdata[0] = mbox_en_w[c];
      if (bus_addr == AW'(OFS_PEND + 4*c))
        bus_rdata[PW-1:0] = pend_w[c];
    end
  end
endmodule

// File: rtl/lirq_agg_chk.sv
module lirq_agg_chk
  import lirq_pkg::*;
#(
  parameter int NC = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [NC*NTMR-1:0] tmr_irq_in,
  input logic [NC-1:0]      mbox_irq_in,
  input logic [NC-1:0]      pmu_irq_in,
  input logic               fast_irq_in,
  input logic [NC-1:0]      core_irq,
  input logic [NC*NTMR-1:0] tmr_en,
  input logic [NC-1:0]      mbox_en,
  input logic [NC-1:0]      pmu_route
);
  logic set_w, clr_w, pend_w, tmr_win;
  assign set_w   = bus_wr && (bus_addr == AW'(OFS_PMU_SET));
  assign clr_w   = bus_wr && (bus_addr == AW'(OFS_PMU_CLR));
  assign pend_w  = bus_wr && (bus_addr >= AW'(OFS_PEND)) && (bus_addr < AW'(OFS_PEND + 4*NC));
  assign tmr_win = (bus_addr >= AW'(OFS_TMR)) && (bus_addr < AW'(OFS_TMR + 4*NC));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> ((pmu_route & $past(bus_wdata[NC-1:0])) == $past(bus_wdata[NC-1:0])));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((pmu_route & $past(bus_wdata[NC-1:0])) == '0));

  p_route_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_w || clr_w) |=> $stable(pmu_route));

  p_pend_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |=> ($stable(pmu_route) && $stable(tmr_en) && $stable(mbox_en)));

  p_tmr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_win |-> (bus_rdata[DW-1:NTMR] == '0));

  p_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq_in |-> core_irq[0]);

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic any_src;
    assign any_src = (|(tmr_irq_in[c*NTMR +: NTMR] & tmr_en[c*NTMR +: NTMR]))
                   || (mbox_irq_in[c] && mbox_en[c])
                   || (pmu_irq_in[c] && pmu_route[c])
                   || ((c == 0) && fast_irq_in);
    p_irq_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_src == core_irq[c]);
  end
endmodule

bind lirq_agg lirq_agg_chk #(.NC(NC), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .tmr_irq_in  (tmr_irq_in),
  .mbox_irq_in (mbox_irq_in),
  .pmu_irq_in  (pmu_irq_in),
  .fast_irq_in (fast_irq_in),
  .core_irq    (core_irq),
  .tmr_en      (tmr_en_w),
  .mbox_en     (mbox_en_w),
  .pmu_route   (pmu_route_w)
);

// File: tb/lirq_agg_tb.sv
module lirq_agg_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_irq_in = '0;
  logic [3:0]  mbox_irq_in = '0;
  logic [3:0]  pmu_irq_in = '0;
  logic        fast_irq_in = 1'b0;
  logic [3:0]  core_irq;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  lirq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq_in(tmr_irq_in),
    .mbox_irq_in(mbox_irq_in), .pmu_irq_in(pmu_irq_in),
    .fast_irq_in(fast_irq_in), .core_irq(core_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_pend(input int c, input logic [3:0] t, input logic [3:0] te,
                                           input logic mb, input logic me, input logic f,
                                           input logic p, input logic pr);
    logic [31:0] v;
    v = 32'(t & te);
    v = v + (32'(mb & me) << 4);
    v = v + ((c == 0) ? (32'(f) << 8) : 32'd0);
    v = v + (32'(p & pr) << 9);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h40 + 4*c), d); chk("R1 tmr en", d, 0);
      rd(8'(8'h50 + 4*c), d); chk("R1 mbox en", d, 0);
      rd(8'(8'h60 + 4*c), d); chk("R1 pend", d, 0);
    end
    rd(8'h08, d); chk("R1 route", d, 0);
    chk("R1 irq", 32'(core_irq), 0);

    // R2, R5, R6: timer enable x timer input sweep per core
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 16; e++) begin
        wr(8'(8'h40 + 4*c), 32'hABCDE0F0 | 32'(e));
        rd(8'(8'h40 + 4*c), d); chk("R2 tmr readback", d, 32'(e));
        for (int t = 0; t < 16; t++) begin
          tmr_irq_in = {4{4'(t)}};
          rd(8'(8'h60 + 4*c), d);
          chk("R5 tmr pend", d, exp_pend(c, 4'(t), 4'(e), 0, 0, 0, 0, 0));
          chk("R6 irq", 32'(core_irq[c]), 32'((t & e) != 0));
        end
      end
      wr(8'(8'h40 + 4*c), 0);
    end
    tmr_irq_in = '0;

    // R3, R5: mailbox enable x input
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 2; e++) begin
        wr(8'(8'h50 + 4*c), 32'hFFFFFFFE | 32'(e));
        rd(8'(8'h50 + 4*c), d); chk("R3 mbox readback", d, 32'(e));
        for (int m = 0; m < 2; m++) begin
          mbox_irq_in = 4'(m) << c;
          rd(8'(8'h60 + 4*c), d);
          chk("R5 mbox pend", d, exp_pend(c, 0, 0, 1'(m), 1'(e), 0, 0, 0));
        end
      end
      wr(8'(8'h50 + 4*c), 0);
    end
    mbox_irq_in = '0;

    // R4, R5: routing via set/clear
    pmu_irq_in = 4'hF;
    for (int m = 0; m < 16; m++) begin
      wr(8'h0C, 32'hF);
      wr(8'h08, 32'hFFFFFFF0 | 32'(m));
      rd(8'h08, d); chk("R4 set", d, 32'(m));
      chk("R4 irq route", 32'(core_irq), 32'(m));
      for (int c = 0; c < 4; c++) begin
        rd(8'(8'h60 + 4*c), d);
        chk("R5 pmu pend", d, exp_pend(c, 0, 0, 0, 0, 0, 1, 1'((m >> c) & 1)));
      end
      wr(8'h0C, 32'(m ^ 5));
      rd(8'h0C, d); chk("R4 clr", d, 32'(m & ~(m ^ 5) & 15));
    end
    wr(8'h0C, 32'hF);
    pmu_irq_in = '0;

    // R5: fast line goes to core 0 only
    fast_irq_in = 1'b1;
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h60 + 4*c), d);
      chk("R5 fast pend", d, exp_pend(c, 0, 0, 0, 0, 1, 0, 0));
    end
    chk("R5 fast irq", 32'(core_irq), 32'h1);
    fast_irq_in = 1'b0;
    #1;
    chk("R6 fast release", 32'(core_irq), 0);

    // R7: pend and unmapped writes ignored
    wr(8'h08, 32'h5);
    wr(8'h44, 32'h3);
    wr(8'h64, 32'hFFFFFFFF);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h42, 32'hFFFFFFFF);
    rd(8'h08, d); chk("R7 route kept", d, 32'h5);
    rd(8'h44, d); chk("R7 tmr kept", d, 32'h3);
    rd(8'h40, d); chk("R7 tmr0 kept", d, 32'h0);
    rd(8'h54, d); chk("R7 mbox kept", d, 32'h0);
    rd(8'h20, d); chk("R7 unmapped read", d, 0);
    wr(8'h0C, 32'hF);
    wr(8'h44, 32'h0);

    // R8: write visible only after capturing edge
    tmr_irq_in = 16'h00F0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h2;
    #1;
    chk("R8 before edge", 32'(core_irq[1]), 0);
    @(posedge clk);
    #1;
    chk("R8 after edge", 32'(core_irq[1]), 1);
    bus_wr = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule